// File: doc/BRIEF.md
# Indirect Interrupt Routing Register File

This block holds the routing state for a set of interrupt input pins and lets a host reach it through only two bus locations. The host first writes an 8-bit select value, then reads or writes a 32-bit data window. The select value picks one of three targets: a 4-bit identification field, a read-only version word, or one 32-bit half of a 64-bit routing entry. There is one routing entry for each input pin. A third location accepts an end-of-interrupt vector and passes it on as a one-cycle pulse.

Every routing entry is always visible on a flat output bus, so a companion interrupt service unit can act on it. The service unit reports back through a per-pin input that sets an entry's remote-pending flag. Each time a host write lands on a valid entry, the block raises a one-cycle update strobe that carries the entry index.

Host reads answer one cycle after the request. The low four address bits are ignored, because accesses are expected on 16-byte boundaries.

Top module: `irq_route_regs`

## Requirements
- R1: Offset 0x00 holds the select register, which is 8 bits wide. A write keeps only data bits 7:0, and a read at 0x00 returns the select value zero-extended.
- R2: When select is 0x01, a window read returns (NPINS-1) in bits 23:16 and VERSION in bits 7:0, with every other bit zero. A window write with this select changes nothing.
- R3: When select is 0x00, a window write stores data bits 27:24 as the ID. A window read returns the ID in bits 27:24 and zero in every other bit.
- R4: For a select value of 0x10 or more, the entry index is (select-0x10)>>1. An odd select reaches entry bits 63:32 and an even select reaches bits 31:0. Entry k appears on tbl_flat[64k+63:64k]. Its fields are vector [7:0], delivery mode [10:8], destination mode [11], remote-pending [14], trigger mode [15] (1 = level), mask [16] and destination [63:56].
- R5: A window read of an entry index at or beyond NPINS returns 0xFFFFFFFF. A window write to such an index changes no entry and raises no update strobe.
- R6: A window write to the low half of an entry stores the data with bit 14 forced to 0, which clears remote-pending. A write to the high half leaves remote-pending unchanged. A pulse on pend_set[k] sets remote-pending of entry k in the next cycle, unless a low-half write to entry k happens in the same cycle.
- R7: After reset, every entry holds only its mask bit (0x0000_0000_0001_0000), and both select and ID are zero.
- R8: A window write to an entry index below NPINS makes upd_valid high for exactly the next cycle, with upd_index equal to that entry index.
- R9: The window sits at offset 0x10. An offset other than 0x00, 0x10 and 0x40 reads as zero and ignores writes. Select values 0x02 to 0x0F read as zero through the window and ignore window writes.
- R10: A write at offset 0x40 makes eoi_valid high for the next cycle, with eoi_vector equal to data bits 7:0. A read at 0x40 returns zero.
- R11: A read request is answered one cycle later, with rd_valid high for that cycle and the read data on rd_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset (bits 7:4 decoded) |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| pend_set | input | NPINS | Per-pin remote-pending set from the service unit |
| tbl_flat | output | NPINS*64 | All routing entries, entry k at bits 64k+63:64k |
| upd_valid | output | 1 | An entry was written |
| upd_index | output | IDX_W | Index of the written entry |
| eoi_valid | output | 1 | End-of-interrupt pulse |
| eoi_vector | output | 8 | Vector carried with the end-of-interrupt pulse |

## Verification
A table of select/data pairs is written and then read back through the window. The table covers the ID and version registers, both halves of the first and last valid entries, a mid-table entry, the first out-of-range index, the largest possible select, and an unused select below 0x10. Together these separate the decoding of the index from the decoding of the half, and show where the valid range ends. Directed tests cover the remote-pending flag. The flag is set from the service side, survives a high-half write, and is cleared by a low-half write. Further directed tests check the update and end-of-interrupt strobes, unmapped offsets, select truncation and the reset contents.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    typedef enum logic [1:0] {SK_ID, SK_VER, SK_ENTRY, SK_NONE} sel_kind_e;
    typedef enum logic [1:0] {OFF_SEL, OFF_WIN, OFF_EOI, OFF_NONE} off_kind_e;
    localparam int ENT_W    = 64;
    localparam int HALF_W   = 32;
    localparam int SEL_W    = 8;
    localparam int RP_BIT   = 14;
    localparam int MASK_BIT = 16;
    localparam logic [SEL_W-1:0] ENT_BASE = 8'h10;
    localparam logic [ENT_W-1:0] ENT_RESET = 64'h1 << MASK_BIT;
endpackage

// File: rtl/route_sel_decode.sv
module route_sel_decode
    import irq_route_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int IDX_W = 5
) (
    input  logic [SEL_W-1:0] sel,
    output sel_kind_e        kind,
    output logic [IDX_W-1:0] idx,
    output logic             hi,
    output logic             in_range
);
    logic [SEL_W-1:0] rel;
    logic [SEL_W-2:0] full_idx;

    always_comb begin
        rel      = sel - ENT_BASE;
        full_idx = rel[SEL_W-1:1];
        hi       = sel[0];
        idx      = full_idx[IDX_W-1:0];
        in_range = (sel >= ENT_BASE) && (int'(full_idx) < NPINS);
        if (sel == 8'h00)        kind = SK_ID;
        else if (sel == 8'h01)   kind = SK_VER;
        else if (sel >= ENT_BASE) kind = SK_ENTRY;
        else                     kind = SK_NONE;
    end
endmodule

// File: rtl/route_entry_table.sv
module route_entry_table
    import irq_route_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int IDX_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   wr_hi,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [HALF_W-1:0]      wr_data,
    input  logic [NPINS-1:0]       pend_set,
    input  logic [IDX_W-1:0]       rd_idx,
    input  logic                   rd_hi,
    output logic [HALF_W-1:0]      rd_word,
    output logic [NPINS*ENT_W-1:0] tbl_flat
);
    logic [ENT_W-1:0] ent [NPINS];

    for (genvar k = 0; k < NPINS; k++) begin : g_ent
        logic hit, lo_hit;
        assign hit    = wr_en && (int'(wr_idx) == k);
        assign lo_hit = hit && !wr_hi;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent[k] <= ENT_RESET;
            end else begin
                if (hit && wr_hi)
                    ent[k][ENT_W-1:HALF_W] <= wr_data;
                if (lo_hit)
                    ent[k][HALF_W-1:0] <= {wr_data[HALF_W-1:RP_BIT+1], 1'b0, wr_data[RP_BIT-1:0]};
                else if (pend_set[k])
                    ent[k][RP_BIT] <= 1'b1;
            end
        end

        assign tbl_flat[k*ENT_W +: ENT_W] = ent[k];

        assert_lo_clears_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
            lo_hit |=> !tbl_flat[k*ENT_W + RP_BIT]);
        assert_hi_keeps_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && wr_hi && !pend_set[k]) |=>
                tbl_flat[k*ENT_W + RP_BIT] == $past(tbl_flat[k*ENT_W + RP_BIT]));
    end

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < NPINS; k++)
            if (int'(rd_idx) == k)
                rd_word = rd_hi ? ent[k][ENT_W-1:HALF_W] : ent[k][HALF_W-1:0];
    end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NPINS = 24,
    parameter logic [7:0] VERSION = 8'h11,
    parameter int ID_W = 4,
    localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [7:0]             req_addr,
    input  logic [31:0]            req_wdata,
    output logic                   rd_valid,
    output logic [31:0]            rd_data,
    input  logic [NPINS-1:0]       pend_set,
    output logic [NPINS*64-1:0]    tbl_flat,
    output logic                   upd_valid,
    output logic [IDX_W-1:0]       upd_index,
    output logic                   eoi_valid,
    output logic [7:0]             eoi_vector
);
    localparam int ID_LSB = 24;
    localparam logic [7:0] MAX_PIN = 8'(NPINS - 1);

    logic [SEL_W-1:0] sel_q;
    logic [ID_W-1:0]  id_q;
    off_kind_e        off;
    sel_kind_e        kind;
    logic [IDX_W-1:0] idx;
    logic             hi, in_range;
    logic             wr_req, rd_req, tbl_wr;
    logic [31:0]      tbl_word, win_word, rd_next;

    always_comb begin
        unique case (req_addr[7:4])
            4'h0:    off = OFF_SEL;
            4'h1:    off = OFF_WIN;
            4'h4:    off = OFF_EOI;
            default: off = OFF_NONE;
        endcase
    end

    assign wr_req = req_valid && req_write;
    assign rd_req = req_valid && !req_write;
    assign tbl_wr = wr_req && (off == OFF_WIN) && (kind == SK_ENTRY) && in_range;

    route_sel_decode #(.NPINS(NPINS), .IDX_W(IDX_W)) u_dec (
        .sel(sel_q), .kind(kind), .idx(idx), .hi(hi), .in_range(in_range)
    );

    route_entry_table #(.NPINS(NPINS), .IDX_W(IDX_W)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_wr), .wr_hi(hi), .wr_idx(idx), .wr_data(req_wdata),
        .pend_set(pend_set), .rd_idx(idx), .rd_hi(hi),
        .rd_word(tbl_word), .tbl_flat(tbl_flat)
    );

    always_comb begin
        unique case (kind)
            SK_ID:    win_word = 32'(id_q) << ID_LSB;
            SK_VER:   win_word = {8'h00, MAX_PIN, 8'h00, VERSION};
            SK_ENTRY: win_word = in_range ? tbl_word : '1;
            default:  win_word = '0;
        endcase
        unique case (off)
            OFF_SEL: rd_next = {24'h0, sel_q};
            OFF_WIN: rd_next = win_word;
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q      <= '0;
            id_q       <= '0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            upd_valid  <= 1'b0;
            upd_index  <= '0;
            eoi_valid  <= 1'b0;
            eoi_vector <= '0;
        end else begin
            rd_valid  <= rd_req;
            if (rd_req) rd_data <= rd_next;
            upd_valid <= tbl_wr;
            if (tbl_wr) upd_index <= idx;
            eoi_valid <= wr_req && (off == OFF_EOI);
            if (wr_req && off == OFF_EOI) eoi_vector <= req_wdata[7:0];
            if (wr_req && off == OFF_SEL) sel_q <= req_wdata[SEL_W-1:0];
            if (wr_req && off == OFF_WIN && kind == SK_ID)
                id_q <= req_wdata[ID_LSB +: ID_W];
        end
    end

    assert_rd_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    assert_upd_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (int'(upd_index) < NPINS));
    assert_upd_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_valid) |-> $past(req_valid && req_write));
    assert_eoi_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> $past(req_valid && req_write && req_addr[7:4] == 4'h4));
endmodule

// File: tb/tb_irq_route_regs.sv
`timescale 1ns/1ps
module tb_irq_route_regs;
    localparam int NPINS = 24;
    localparam int IDX_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [7:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic rd_valid;
    logic [31:0] rd_data;
    logic [NPINS-1:0] pend_set = '0;
    logic [NPINS*64-1:0] tbl_flat;
    logic upd_valid, eoi_valid;
    logic [IDX_W-1:0] upd_index;
    logic [7:0] eoi_vector;

    int checks = 0, failures = 0;
    logic done = 1'b0;
    logic seen_upd, seen_eoi;
    logic [IDX_W-1:0] seen_idx;
    logic [7:0] seen_vec;

    always #2.5 clk = ~clk;

    irq_route_regs dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .pend_set(pend_set), .tbl_flat(tbl_flat), .upd_valid(upd_valid),
        .upd_index(upd_index), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
    );

    typedef struct packed {
        logic [7:0]  sel;
        logic        wr;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{8'h00, 1'b1, 32'hA5FF_FFFF, 32'h0500_0000},
        '{8'h01, 1'b1, 32'hFFFF_FFFF, 32'h0017_0011},
        '{8'h10, 1'b1, 32'h0001_E0F3, 32'h0001_A0F3},
        '{8'h11, 1'b1, 32'hAB00_0000, 32'hAB00_0000},
        '{8'h3F, 1'b1, 32'h1234_5678, 32'h1234_5678},
        '{8'h3E, 1'b0, 32'h0000_0000, 32'h0001_0000},
        '{8'h40, 1'b1, 32'h5555_5555, 32'hFFFF_FFFF},
        '{8'hFF, 1'b1, 32'h0000_0000, 32'hFFFF_FFFF},
        '{8'h02, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000},
        '{8'h2C, 1'b1, 32'h0000_0142, 32'h0000_0142}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        seen_upd = upd_valid; seen_idx = upd_index;
        seen_eoi = eoi_valid; seen_vec = eoi_vector;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 rd_valid", 64'(rd_valid), 64'd1);
        d = rd_data;
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset contents
        for (int k = 0; k < NPINS; k++)
            check("R7 entry reset", tbl_flat[k*64 +: 64], 64'h0000_0000_0001_0000);
        bus_read(8'h00, r);
        check("R7 select reset", 64'(r), 64'h0);
        bus_read(8'h10, r);
        check("R7 id reset", 64'(r), 64'h0);

        // Vector table: R2 R3 R4 R5 R9
        for (int i = 0; i < 10; i++) begin
            bus_write(8'h00, 32'(VECS[i].sel));
            if (VECS[i].wr) bus_write(8'h10, VECS[i].wd);
            bus_read(8'h10, r);
            check($sformatf("R4 vector %0d sel=%h", i, VECS[i].sel), 64'(r), 64'(VECS[i].exp));
        end
        check("R4 entry0 on tbl_flat", tbl_flat[0 +: 64], 64'hAB00_0000_0001_A0F3);
        check("R4 entry23 on tbl_flat", tbl_flat[23*64 +: 64], 64'h1234_5678_0001_0000);
        check("R4 entry14 on tbl_flat", tbl_flat[14*64 +: 64], 64'h0000_0000_0000_0142);

        // R1 select truncation
        bus_write(8'h00, 32'h1234_5621);
        bus_read(8'h00, r);
        check("R1 select 8 bits", 64'(r), 64'h21);

        // R8 strobe on in-range write, R5 no strobe out of range
        bus_write(8'h00, 32'h1B);
        bus_write(8'h10, 32'h0000_0000);
        check("R8 upd_valid", 64'(seen_upd), 64'd1);
        check("R8 upd_index", 64'(seen_idx), 64'd5);
        @(negedge clk);
        check("R8 upd one cycle", 64'(upd_valid), 64'd0);
        bus_write(8'h00, 32'h40);
        bus_write(8'h10, 32'h1111_1111);
        check("R5 no strobe", 64'(seen_upd), 64'd0);

        // R6 remote-pending on entry 5 (select 0x1A low, 0x1B high)
        @(negedge clk); pend_set[5] = 1'b1;
        @(negedge clk); pend_set[5] = 1'b0;
        check("R6 pend_set", 64'(tbl_flat[5*64+14]), 64'd1);
        bus_write(8'h00, 32'h1B);
        bus_write(8'h10, 32'h7700_0000);
        check("R6 high write keeps", 64'(tbl_flat[5*64+14]), 64'd1);
        bus_write(8'h00, 32'h1A);
        bus_read(8'h10, r);
        check("R6 read pending", 64'(r), 64'h0001_4000);
        bus_write(8'h10, 32'h0000_4033);
        bus_read(8'h10, r);
        check("R6 low write clears", 64'(r), 64'h0000_0033);

        // R9 unmapped offset
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_read(8'h20, r);
        check("R9 unmapped reads zero", 64'(r), 64'h0);
        bus_read(8'h00, r);
        check("R9 unmapped write ignored", 64'(r), 64'h1A);

        // R10 end-of-interrupt
        bus_write(8'h40, 32'h0000_0123);
        check("R10 eoi_valid", 64'(seen_eoi), 64'd1);
        check("R10 eoi_vector", 64'(seen_vec), 64'h23);
        bus_read(8'h40, r);
        check("R10 eoi reads zero", 64'(r), 64'h0);
        check("R10 eoi one cycle", 64'(eoi_valid), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule